// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM needs an auto-refresh and runs the command sequence for it. A free-running interval timer fires once per refresh slot. The slot length is the retention window divided among 8192 refreshes, counted in clock cycles at the configured clock frequency. A temperature-grade input chooses between the normal 64 ms window and the shortened 16 ms window. Each slot that fires adds one to a small debt counter. While the debt is non-zero the scheduler raises a request to the access arbiter and waits for a grant.

Once granted, the scheduler owns the command pins. It first issues a precharge of all banks, because a refresh is only legal when every bank is idle. It then waits the precharge time and issues auto-refresh commands back to back, each followed by a hold-off of the refresh cycle time, until the debt is paid. After that it drops the request and hands the pins back. Up to eight slots can be owed while the arbiter is busy; slots beyond that are not counted.

States: `ST_IDLE` (no debt, pins idle), `ST_WAIT_GNT` (request raised, waiting for grant), `ST_PALL` (precharge-all issued for one cycle), `ST_TRP` (precharge time), `ST_REF` (refresh issued for one cycle), `ST_TRC` (refresh cycle time). Transitions: IDLE→WAIT_GNT when debt becomes non-zero; WAIT_GNT→PALL on grant; PALL→TRP always; TRP→REF when the precharge timer expires; REF→TRC always; TRC→REF when the timer expires and debt remains; TRC→IDLE when the timer expires and no debt remains.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and right after it, `rf_req`, `pall_stb` and `ref_stb` are low and `cmd_n` shows NOP (4'b0111 on {cs,ras,cas,we}).
- R2: With `hot_sel` low and grant always high, refresh commands repeat every floor(CLK_MHZ*1000*64/8192) cycles, which is 1562 at 200 MHz. The first request rises no earlier than that many cycles after reset.
- R3: With `hot_sel` high, the refresh period is floor(CLK_MHZ*1000*16/8192) cycles, which is 390 at 200 MHz.
- R4: Each granted sequence begins with one precharge-all cycle. In that cycle `pall_stb` is high, `cmd_n` is 4'b0010 and `addr10` is high. The first refresh follows at least TRP_CYC cycles later.
- R5: A refresh cycle drives `cmd_n` to 4'b0001 with `ref_stb` high. In every other cycle outside precharge-all, `cmd_n` is NOP (4'b0111).
- R6: While `grant` is low, no command other than NOP is issued, and `rf_req` stays high once raised.
- R7: The debt saturates at 8. After ten or more slots pass without a grant, exactly 8 refresh commands are issued once grant arrives.
- R8: Successive refresh commands are at least TRC_CYC cycles apart, with only NOP between them.
- R9: A burst that pays back several owed refreshes uses one precharge-all only. `rf_req` falls after the last refresh's hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_sel | input | 1 | 1 selects the 16 ms retention window |
| grant | input | 1 | Arbiter grants the command pins to the scheduler |
| rf_req | output | 1 | Scheduler requests the command pins |
| pall_stb | output | 1 | Precharge-all command issued this cycle |
| ref_stb | output | 1 | Auto-refresh command issued this cycle |
| cmd_n | output | 4 | Command pins {cs_n, ras_n, cas_n, we_n} |
| addr10 | output | 1 | Address bit 10 (high for precharge-all) |

## Verification
The main function is driven in three ways. With grant held high in the normal window, the measured refresh-to-refresh spacing must equal the cold period. The same run in the short window must show the hot period, which separates the two divisors. With grant held low across ten short-window slots and then released, the run separates saturation at eight from unbounded counting. It also confirms the pins stay at NOP while ungranted, and that the payback burst uses a single precharge-all with refreshes spaced by the refresh cycle time.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_PALL,
        ST_TRP,
        ST_REF,
        ST_TRC
    } sched_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
    parameter int unsigned LIM_COLD = 1562,
    parameter int unsigned LIM_HOT  = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic hot_sel,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(LIM_COLD + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        limit_m1 = hot_sel ? CNT_W'(LIM_HOT - 1) : CNT_W'(LIM_COLD - 1);
        tick     = (cnt >= limit_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic owed
);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);

    logic [DW-1:0] debt;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
                2'b01: if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign owed = (debt != '0);
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
    import refresh_pkg::*;
#(
    parameter int unsigned TRP_CYC = 3,
    parameter int unsigned TRC_CYC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       owed,
    input  logic       grant,
    output logic       rf_req,
    output logic       pall_stb,
    output logic       ref_stb,
    output logic [3:0] cmd_n,
    output logic       addr10
);
    localparam int unsigned MAXW = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
    localparam int unsigned WW   = $clog2(MAXW + 1);

    sched_state_t   state, nxt;
    logic [WW-1:0]  wcnt;

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (owed) nxt = ST_WAIT_GNT;
            ST_WAIT_GNT: if (grant) nxt = ST_PALL;
            ST_PALL:     nxt = ST_TRP;
            ST_TRP:      if (wcnt == '0) nxt = ST_REF;
            ST_REF:      nxt = ST_TRC;
            ST_TRC:      if (wcnt == '0) nxt = owed ? ST_REF : ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register and wait timer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PALL) begin
                wcnt <= WW'(TRP_CYC - 1);
            end else if (state == ST_REF) begin
                wcnt <= WW'(TRC_CYC - 1);
            end else if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rf_req   = (state != ST_IDLE);
        pall_stb = 1'b0;
        ref_stb  = 1'b0;
        cmd_n    = CMD_NOP;
        addr10   = 1'b0;
        unique case (state)
            ST_PALL: begin
                pall_stb = 1'b1;
                cmd_n    = CMD_PALL;
                addr10   = 1'b1;
            end
            ST_REF: begin
                ref_stb = 1'b1;
                cmd_n   = CMD_REF;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned CLK_MHZ      = 200,
    parameter int unsigned REFS_PER_WIN = 8192,
    parameter int unsigned WIN_MS       = 64,
    parameter int unsigned HOT_WIN_MS   = 16,
    parameter int unsigned DEBT_MAX     = 8,
    parameter int unsigned TRP_CYC      = 3,
    parameter int unsigned TRC_CYC      = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hot_sel,
    input  logic       grant,
    output logic       rf_req,
    output logic       pall_stb,
    output logic       ref_stb,
    output logic [3:0] cmd_n,
    output logic       addr10
);
    localparam int unsigned CYC_COLD = (CLK_MHZ * 1000 * WIN_MS) / REFS_PER_WIN;
    localparam int unsigned CYC_HOT  = (CLK_MHZ * 1000 * HOT_WIN_MS) / REFS_PER_WIN;

    logic tick;
    logic owed;

    refresh_tick_gen #(.LIM_COLD(CYC_COLD), .LIM_HOT(CYC_HOT)) u_tick (
        .clk(clk), .rst(rst), .hot_sel(hot_sel), .tick(tick)
    );

    refresh_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk(clk), .rst(rst), .inc(tick), .dec(ref_stb), .owed(owed)
    );

    refresh_seq_fsm #(.TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC)) u_fsm (
        .clk(clk), .rst(rst), .owed(owed), .grant(grant),
        .rf_req(rf_req), .pall_stb(pall_stb), .ref_stb(ref_stb),
        .cmd_n(cmd_n), .addr10(addr10)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned TRC_CYC = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       grant,
    input logic       rf_req,
    input logic       pall_stb,
    input logic       ref_stb,
    input logic [3:0] cmd_n,
    input logic       addr10
);
    localparam int unsigned SW = $clog2(TRC_CYC + 1);
    logic [SW-1:0] since_ref;

    always_ff @(posedge clk) begin
        if (rst)                           since_ref <= SW'(TRC_CYC);
        else if (ref_stb)                  since_ref <= '0;
        else if (since_ref != SW'(TRC_CYC)) since_ref <= since_ref + 1'b1;
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pall_stb, ref_stb}));

    // R6
    pall_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        pall_stb |-> $past(grant));

    // R4
    pall_pins_chk: assert property (@(posedge clk) disable iff (rst)
        pall_stb |-> (cmd_n == 4'b0010 && addr10));

    // R8
    trc_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_stb || pall_stb) |-> (since_ref == SW'(TRC_CYC)));

    // R1
    idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !rf_req |-> (cmd_n == 4'b0111 && !pall_stb && !ref_stb));
endmodule

bind refresh_sched refresh_sched_chk #(.TRC_CYC(TRC_CYC)) u_chk (
    .clk(clk), .rst(rst), .grant(grant), .rf_req(rf_req),
    .pall_stb(pall_stb), .ref_stb(ref_stb), .cmd_n(cmd_n), .addr10(addr10)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int CLK_PERIOD = 5;
    localparam int EXP_COLD   = 200 * 1000 * 64 / 8192;  // 1562
    localparam int EXP_HOT    = 200 * 1000 * 16 / 8192;  // 390
    localparam int TRP        = 3;
    localparam int TRC        = 10;

    logic clk = 0, rst = 1, hot_sel = 0, grant = 0;
    logic rf_req, pall_stb, ref_stb, addr10;
    logic [3:0] cmd_n;
    int checks = 0, errors = 0;
    bit  timed_out = 0;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    refresh_sched uut (
        .clk(clk), .rst(rst), .hot_sel(hot_sel), .grant(grant),
        .rf_req(rf_req), .pall_stb(pall_stb), .ref_stb(ref_stb),
        .cmd_n(cmd_n), .addr10(addr10)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit hot, input bit g);
        @(negedge clk);
        rst = 1; hot_sel = hot; grant = g;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // waits for ref_stb at negedge; returns cycles waited
    task automatic wait_ref(output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!ref_stb && n < 5000);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1; grant = 1;
        repeat (2) @(negedge clk);
        check("R1 rf_req in reset", !rf_req, rf_req, 0);
        check("R1 strobes in reset", !pall_stb && !ref_stb, {pall_stb, ref_stb}, 0);
        check("R1 cmd NOP in reset", cmd_n == 4'b0111, cmd_n, 4'b0111);
        rst = 0;
        @(negedge clk);
        check("R1 cmd NOP after reset", cmd_n == 4'b0111 && !rf_req, cmd_n, 4'b0111);
    endtask

    task automatic t_cold;
        int n, first, pall_at, ref_at, gap;
        do_reset(0, 1);
        n = 0; first = -1; pall_at = -1; ref_at = -1;
        while (ref_at < 0 && n < 3000) begin
            @(negedge clk); n++;
            if (rf_req && first < 0) first = n;
            if (pall_stb) begin
                pall_at = n;
                check("R4 pall encoding", cmd_n == 4'b0010 && addr10, {cmd_n, addr10}, 5'b00101);
            end
            if (ref_stb) begin
                ref_at = n;
                check("R5 ref encoding", cmd_n == 4'b0001, cmd_n, 4'b0001);
            end
        end
        check("R2 first request not early", first >= EXP_COLD && first <= EXP_COLD + 2, first, EXP_COLD);
        check("R4 pall precedes ref by TRP", pall_at > 0 && ref_at - pall_at >= TRP, ref_at - pall_at, TRP);
        wait_ref(gap);
        check("R2 cold period", gap == EXP_COLD, gap, EXP_COLD);
    endtask

    task automatic t_hot;
        int gap;
        do_reset(1, 1);
        wait_ref(gap);
        wait_ref(gap);
        check("R3 hot period", gap == EXP_HOT, gap, EXP_HOT);
        wait_ref(gap);
        check("R3 hot period again", gap == EXP_HOT, gap, EXP_HOT);
    endtask

    task automatic t_debt;
        int bad = 0, refs = 0, palls = 0, last = -1000, mingap = 100000, n = 0, nop_bad = 0;
        do_reset(1, 0);
        for (int i = 0; i < 10 * EXP_HOT + 10; i++) begin
            @(negedge clk);
            if (pall_stb || ref_stb || cmd_n != 4'b0111) bad++;
        end
        check("R6 no command without grant", bad == 0, bad, 0);
        check("R6 request held", rf_req, rf_req, 1);
        grant = 1;
        while (rf_req && n < 2000) begin
            @(negedge clk); n++;
            if (pall_stb) palls++;
            if (ref_stb) begin
                refs++;
                if (n - last < mingap) mingap = n - last;
                last = n;
            end else if (!pall_stb && cmd_n != 4'b0111) nop_bad++;
        end
        check("R7 saturated debt paid", refs == 8, refs, 8);
        check("R9 single precharge-all per burst", palls == 1, palls, 1);
        check("R8 refresh spacing", mingap >= TRC, mingap, TRC);
        check("R8 NOP between refreshes", nop_bad == 0, nop_bad, 0);
        @(negedge clk);
        check("R9 request released", !rf_req && n - last >= TRC, n - last, TRC);
    endtask

    initial begin
        t_reset();
        t_cold();
        t_hot();
        t_debt();
        if (!timed_out) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule